// File: doc/BRIEF.md
# Converter Power-Up Register Sequencer

This block brings an external high-speed converter from power-up to a locked and tracking state without any software involvement. After a start pulse it walks through a fixed, ordered list of steps. The steps are SPI register writes, timed waits and register reads whose value is compared against an expected pattern. A failed comparison sends the walk back to the disable write of the controller being checked. That controller is then re-armed and checked again, up to a bounded number of attempts.

Three lock stages are checked in turn: the clock multiplier loop, the synchronisation controller and the data receiver loop. Each stage has its own failure code, which is reported when that stage runs out of attempts. A master/slave select input chooses the synchronisation controller's configuration values. Wait lengths and the serial clock divider are parameters, so a fast simulation can shorten them.

Top module: `spi_init_seq`

## Requirements
- R1: While reset is held and right after it, `spi_cs_n` is 1, `spi_sclk` is 0, and `busy`, `done` and `fail_code` are 0.
- R2: Every transaction is one 16-bit frame with `spi_cs_n` low throughout. Bit 15 is the read flag (1 = read), bits 14:8 are the 7-bit address and bits 7:0 are the data, sent MSB first. `spi_sclk` idles low, MOSI changes only while `spi_sclk` is low, and the slave drives MISO. Each half period of `spi_sclk` is CLK_DIV clocks, so a frame lasts 32*CLK_DIV clocks. Read frames carry data 0x00 on MOSI.
- R3: After a start the frames appear in this exact order, with no other frames. Address 0x00 is written with 0x00, then 0x20 (soft reset), then 0x00. Then 0x22←0x0F, 0x23←0x0F, 0x24←0x30, 0x25←0x80, 0x27←0x44, 0x28←0x6C and 0x29←0xCB. Then 0x26←0x02 and 0x26←0x03, a wait, and a read of 0x2A. Then 0x10←0x00, two sync writes to 0x10, a wait, and a read of 0x0D. Then 0x21←0x00, 0x21←0x02 and 0x21←0x03, a wait, and a read of 0x21. The first write leaves the interface in 4-wire MSB-first mode, and its bits 7:5 equal bits 0:2 mirrored.
- R4: The two sync writes to address 0x10 are 0x60 then 0x70 when `master_sel` is 1, and 0x40 then 0x50 when it is 0.
- R5: The read of 0x2A starts at least WAIT_MU clocks after the 0x26←0x03 frame ends. The read of 0x0D starts at least WAIT_SYNC clocks after the last sync write. The read of 0x21 starts at least WAIT_RX clocks after 0x21←0x03.
- R6: The multiplier stage passes when the read of 0x2A returns exactly 0x01. Otherwise the sequencer repeats from 0x26←0x02. On the third failed read it stops with `fail_code` = 1. A stage that passes after earlier misses continues normally, and the next stage starts with a fresh attempt count.
- R7: The sync stage passes when bits 5:4 of the 0x0D read equal 2'b10, whatever the other bits are. Otherwise it repeats from 0x10←0x00. On the third failed read it stops with `fail_code` = 2.
- R8: The receiver stage passes when the 0x21 read returns exactly 0x09. Otherwise it repeats from 0x21←0x00. On the third failed read it stops with `fail_code` = 3.
- R9: `busy` is 1 from the clock after an accepted start until the sequence ends. On success `done` becomes 1 with `fail_code` 0. On failure `done` stays 0. `done` and `fail_code` keep their values while idle, and an accepted start clears both.
- R10: A start pulse while `busy` is 1 has no effect on the frame sequence or the outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-clock request to run the sequence |
| master_sel | input | 1 | 1 = master sync values, 0 = slave sync values |
| spi_miso | input | 1 | Serial data from the converter |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the converter |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished with all stages locked |
| fail_code | output | 2 | 0 none, 1 multiplier, 2 sync, 3 receiver lock failure |

## Verification
The assertions assume that `start` is a synchronous single-clock pulse and that `master_sel` does not change while `busy` is high. The bench drives both inputs on the falling clock edge, holds `master_sel` for a whole run, and gives `start` for one clock only. The bench's slave model returns its readbacks only in the data half of a read frame. Each stage's readback can be made to fail a chosen number of times and then pass. This reaches every retry path without changing anything the block assumes about its inputs.

// File: rtl/spi_init_pkg.sv
// Shared types for the converter power-up sequencer.
// Assumes: a step index of STEP_AW bits covers the whole step list.
package spi_init_pkg;

    localparam int STEP_AW = 5;

    typedef enum logic [1:0] {OP_WR, OP_CHK, OP_DLY, OP_END} op_e;

    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER, S_WAIT} seq_e;

    typedef struct packed {
        op_e                op;    // kind of step
        logic [6:0]         addr;  // register address
        logic [7:0]         val;   // write value or expected pattern
        logic [7:0]         mask;  // compare mask for checks
        logic [STEP_AW-1:0] back;  // step to resume from on a miss
        logic [1:0]         code;  // failure code of the stage
        logic [1:0]         dsel;  // which wait length a delay uses
    } step_t;

endpackage

// File: rtl/init_step_rom.sv
// Combinational step list for the power-up sequence.
// Assumes: idx beyond the last step reads as OP_END.
module init_step_rom
    import spi_init_pkg::*;
(
    input  logic [STEP_AW-1:0] idx,
    input  logic               master_sel,
    output step_t              st
);

    localparam logic [STEP_AW-1:0] MU_LOOP   = STEP_AW'(10);
    localparam logic [STEP_AW-1:0] SYNC_LOOP = STEP_AW'(14);
    localparam logic [STEP_AW-1:0] RX_LOOP   = STEP_AW'(19);

    function automatic step_t mk(input op_e o, input logic [6:0] a, input logic [7:0] v,
                                 input logic [7:0] m, input logic [STEP_AW-1:0] b,
                                 input logic [1:0] c, input logic [1:0] d);
        step_t s;
        s.op = o; s.addr = a; s.val = v; s.mask = m; s.back = b; s.code = c; s.dsel = d;
        return s;
    endfunction

    // Decode the step index into a step record.
    always_comb begin
        case (idx)
            5'd0:  st = mk(OP_WR,  7'h00, 8'h00, 8'hFF, '0, 2'd0, 2'd0);
            5'd1:  st = mk(OP_WR,  7'h00, 8'h20, 8'hFF, '0, 2'd0, 2'd0);
            5'd2:  st = mk(OP_WR,  7'h00, 8'h00, 8'hFF, '0, 2'd0, 2'd0);
            5'd3:  st = mk(OP_WR,  7'h22, 8'h0F, 8'hFF, '0, 2'd0, 2'd0);
            5'd4:  st = mk(OP_WR,  7'h23, 8'h0F, 8'hFF, '0, 2'd0, 2'd0);
            5'd5:  st = mk(OP_WR,  7'h24, 8'h30, 8'hFF, '0, 2'd0, 2'd0);
            5'd6:  st = mk(OP_WR,  7'h25, 8'h80, 8'hFF, '0, 2'd0, 2'd0);
            5'd7:  st = mk(OP_WR,  7'h27, 8'h44, 8'hFF, '0, 2'd0, 2'd0);
            5'd8:  st = mk(OP_WR,  7'h28, 8'h6C, 8'hFF, '0, 2'd0, 2'd0);
            5'd9:  st = mk(OP_WR,  7'h29, 8'hCB, 8'hFF, '0, 2'd0, 2'd0);
            5'd10: st = mk(OP_WR,  7'h26, 8'h02, 8'hFF, '0, 2'd0, 2'd0);
            5'd11: st = mk(OP_WR,  7'h26, 8'h03, 8'hFF, '0, 2'd0, 2'd0);
            5'd12: st = mk(OP_DLY, 7'h00, 8'h00, 8'hFF, '0, 2'd0, 2'd0);
            5'd13: st = mk(OP_CHK, 7'h2A, 8'h01, 8'hFF, MU_LOOP, 2'd1, 2'd0);
            5'd14: st = mk(OP_WR,  7'h10, 8'h00, 8'hFF, '0, 2'd0, 2'd0);
            5'd15: st = mk(OP_WR,  7'h10, master_sel ? 8'h60 : 8'h40, 8'hFF, '0, 2'd0, 2'd0);
            5'd16: st = mk(OP_WR,  7'h10, master_sel ? 8'h70 : 8'h50, 8'hFF, '0, 2'd0, 2'd0);
            5'd17: st = mk(OP_DLY, 7'h00, 8'h00, 8'hFF, '0, 2'd0, 2'd1);
            5'd18: st = mk(OP_CHK, 7'h0D, 8'h20, 8'h30, SYNC_LOOP, 2'd2, 2'd0);
            5'd19: st = mk(OP_WR,  7'h21, 8'h00, 8'hFF, '0, 2'd0, 2'd0);
            5'd20: st = mk(OP_WR,  7'h21, 8'h02, 8'hFF, '0, 2'd0, 2'd0);
            5'd21: st = mk(OP_WR,  7'h21, 8'h03, 8'hFF, '0, 2'd0, 2'd0);
            5'd22: st = mk(OP_DLY, 7'h00, 8'h00, 8'hFF, '0, 2'd0, 2'd2);
            5'd23: st = mk(OP_CHK, 7'h21, 8'h09, 8'hFF, RX_LOOP, 2'd3, 2'd0);
            default: st = mk(OP_END, 7'h00, 8'h00, 8'hFF, '0, 2'd0, 2'd0);
        endcase
    end

endmodule

// File: rtl/spi_byte_pair.sv
// SPI master for one 16-bit frame: instruction byte then data byte.
// Mode 0: SCLK idles low, MOSI moves on the falling edge, MISO is taken
// on the rising edge. Assumes: go is only honoured while idle.
module spi_byte_pair #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       rd,
    input  logic [6:0] addr,
    input  logic [7:0] wdata,
    input  logic       miso,
    output logic       sclk,
    output logic       cs_n,
    output logic       mosi,
    output logic       xfer_done,
    output logic [7:0] rdata
);

    localparam int DW    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int FRAME = 16;

    logic [DW-1:0]        div_q;
    logic [FRAME-1:0]     tx_q;
    logic [3:0]           bit_q;
    logic                 act_q;

    // Shift one frame out and collect the returned bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0; tx_q <= '0; bit_q <= '0; act_q <= 1'b0;
            sclk <= 1'b0; cs_n <= 1'b1; xfer_done <= 1'b0; rdata <= '0;
        end else begin
            xfer_done <= 1'b0;
            if (!act_q) begin
                if (go) begin
                    act_q <= 1'b1;
                    cs_n  <= 1'b0;
                    tx_q  <= {rd, addr, wdata};
                    div_q <= '0;
                    bit_q <= '0;
                    sclk  <= 1'b0;
                end
            end else if (div_q == DW'(CLK_DIV - 1)) begin
                div_q <= '0;
                if (!sclk) begin
                    sclk  <= 1'b1;
                    rdata <= {rdata[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_q == 4'(FRAME - 1)) begin
                        act_q     <= 1'b0;
                        cs_n      <= 1'b1;
                        xfer_done <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 4'd1;
                        tx_q  <= {tx_q[FRAME-2:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + DW'(1);
            end
        end
    end

    assign mosi = act_q & tx_q[FRAME-1];

endmodule

// File: rtl/spi_init_seq.sv
// Power-up sequencer: walks the step list, issues SPI frames, waits,
// checks lock readbacks and retries a stage a bounded number of times.
// Assumes: start is a one-clock pulse; master_sel is steady while busy.
module spi_init_seq
    import spi_init_pkg::*;
#(
    parameter int CLK_DIV   = 4,
    parameter int WAIT_MU   = 160000,
    parameter int WAIT_SYNC = 160000,
    parameter int WAIT_RX   = 135000,
    parameter int MAX_TRIES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       master_sel,
    input  logic       spi_miso,
    output logic       spi_sclk,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    output logic       busy,
    output logic       done,
    output logic [1:0] fail_code
);

    localparam int WMAX_A = (WAIT_MU > WAIT_SYNC) ? WAIT_MU : WAIT_SYNC;
    localparam int WMAX   = (WMAX_A > WAIT_RX) ? WMAX_A : WAIT_RX;
    localparam int WW     = $clog2(WMAX + 1);
    localparam int TW     = $clog2(MAX_TRIES + 1);

    seq_e               st_q;
    logic [STEP_AW-1:0] pc_q;
    logic [TW-1:0]      tries_q;
    logic [WW-1:0]      wcnt_q;
    logic               done_q;
    logic [1:0]         fail_q;
    step_t              cur;
    logic               x_go, x_done;
    logic [7:0]         x_rdata;
    logic [WW-1:0]      dly_len;

    init_step_rom u_rom (
        .idx        (pc_q),
        .master_sel (master_sel),
        .st         (cur)
    );

    spi_byte_pair #(.CLK_DIV(CLK_DIV)) u_spi (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (x_go),
        .rd        (cur.op == OP_CHK),
        .addr      (cur.addr),
        .wdata     ((cur.op == OP_WR) ? cur.val : 8'h00),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .xfer_done (x_done),
        .rdata     (x_rdata)
    );

    // Launch a frame when a write or check step is fetched.
    assign x_go = (st_q == S_FETCH) && ((cur.op == OP_WR) || (cur.op == OP_CHK));

    // Pick the wait length for the current delay step.
    always_comb begin
        case (cur.dsel)
            2'd0:    dly_len = WW'(WAIT_MU - 1);
            2'd1:    dly_len = WW'(WAIT_SYNC - 1);
            default: dly_len = WW'(WAIT_RX - 1);
        endcase
    end

    // Step through the list, handle checks, retries and the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= S_IDLE; pc_q <= '0; tries_q <= '0; wcnt_q <= '0;
            done_q <= 1'b0; fail_q <= 2'd0;
        end else begin
            case (st_q)
                S_IDLE: if (start) begin
                    pc_q <= '0; tries_q <= '0; done_q <= 1'b0; fail_q <= 2'd0;
                    st_q <= S_FETCH;
                end
                S_FETCH: case (cur.op)
                    OP_WR, OP_CHK: st_q <= S_XFER;
                    OP_DLY: begin wcnt_q <= dly_len; st_q <= S_WAIT; end
                    default: begin done_q <= 1'b1; st_q <= S_IDLE; end
                endcase
                S_XFER: if (x_done) begin
                    if ((cur.op == OP_CHK) && ((x_rdata & cur.mask) != cur.val)) begin
                        if (tries_q == TW'(MAX_TRIES - 1)) begin
                            fail_q <= cur.code;
                            st_q   <= S_IDLE;
                        end else begin
                            tries_q <= tries_q + TW'(1);
                            pc_q    <= cur.back;
                            st_q    <= S_FETCH;
                        end
                    end else begin
                        if (cur.op == OP_CHK) tries_q <= '0;
                        pc_q <= pc_q + STEP_AW'(1);
                        st_q <= S_FETCH;
                    end
                end
                S_WAIT: if (wcnt_q == '0) begin
                    pc_q <= pc_q + STEP_AW'(1);
                    st_q <= S_FETCH;
                end else begin
                    wcnt_q <= wcnt_q - WW'(1);
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign busy      = (st_q != S_IDLE);
    assign done      = done_q;
    assign fail_code = fail_q;

endmodule

// File: rtl/spi_init_seq_chk.sv
// Checker for the power-up sequencer, attached through bind.
// Assumes: start is synchronous to clk.
module spi_init_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [1:0] fail_code,
    input logic       spi_sclk,
    input logic       spi_cs_n,
    input logic       spi_mosi
);

    // R1
    idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    // R2
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R2
    mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R9
    done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && fail_code == 2'd0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(done) && $stable(fail_code)));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (done == 1'b0 && fail_code == 2'd0));

endmodule

bind spi_init_seq spi_init_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .fail_code (fail_code),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n),
    .spi_mosi  (spi_mosi)
);

// File: tb/test_spi_init_seq.sv
// Directed bench with a converter SPI slave model and a sequence model.
module test_spi_init_seq;

    localparam int CLK_DIV = 2;
    localparam int W_MU = 20, W_SYNC = 24, W_RX = 18;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, master_sel = 1'b1;
    logic spi_miso, spi_sclk, spi_cs_n, spi_mosi, busy, done;
    logic [1:0] fail_code;

    int total = 0, bad = 0, cyc = 0;

    spi_init_seq #(.CLK_DIV(CLK_DIV), .WAIT_MU(W_MU), .WAIT_SYNC(W_SYNC),
                   .WAIT_RX(W_RX), .MAX_TRIES(3)) i_spi_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .master_sel(master_sel),
        .spi_miso(spi_miso), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .busy(busy), .done(done), .fail_code(fail_code));

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    // ---- slave model ----
    logic [15:0] lg [0:255];
    int tst [0:255], tend [0:255];
    int ntr = 0, bcnt = 0;
    logic [15:0] sh = '0;
    logic [7:0] outb = '0;
    int mu_bad, sync_bad, rx_bad, n_mu, n_sync, n_rx;

    assign spi_miso = outb[7];

    always @(negedge spi_cs_n) begin bcnt = 0; if (ntr < 256) tst[ntr] = cyc; end
    always @(posedge spi_cs_n) if (bcnt == 16 && ntr < 256) begin
        lg[ntr] = sh; tend[ntr] = cyc; ntr++; bcnt = 0;
    end
    always @(posedge spi_sclk) begin
        sh = {sh[14:0], spi_mosi};
        bcnt++;
        if (bcnt == 8 && sh[7]) begin
            case (sh[6:0])
                7'h2A: begin outb = (n_mu < mu_bad) ? 8'h00 : 8'h01; n_mu++; end
                7'h0D: begin outb = (n_sync < sync_bad) ? 8'h1F : 8'hA5; n_sync++; end
                7'h21: begin outb = (n_rx < rx_bad) ? 8'h19 : 8'h09; n_rx++; end
                default: outb = 8'h00;
            endcase
        end
    end
    always @(negedge spi_sclk) if (bcnt > 8) outb = {outb[6:0], 1'b0};

    // ---- expected sequence model ----
    logic [15:0] exq [0:255];
    int nexp, exp_fail;

    task automatic push(input logic [15:0] v);
        exq[nexp] = v; nexp++;
    endtask

    task automatic build(input bit m, input int mb, input int sb, input int rb);
        nexp = 0; exp_fail = 0;
        push(16'h0000); push(16'h0020); push(16'h0000); push(16'h220F); push(16'h230F);
        push(16'h2430); push(16'h2580); push(16'h2744); push(16'h286C); push(16'h29CB);
        for (int t = 0; t < 3; t++) begin
            push(16'h2602); push(16'h2603); push(16'hAA00);
            if (t >= mb) break;
            if (t == 2) begin exp_fail = 1; return; end
        end
        for (int t = 0; t < 3; t++) begin
            push(16'h1000); push(m ? 16'h1060 : 16'h1040); push(m ? 16'h1070 : 16'h1050);
            push(16'h8D00);
            if (t >= sb) break;
            if (t == 2) begin exp_fail = 2; return; end
        end
        for (int t = 0; t < 3; t++) begin
            push(16'h2100); push(16'h2102); push(16'h2103); push(16'hA100);
            if (t >= rb) break;
            if (t == 2) begin exp_fail = 3; return; end
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic pulse_start;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // One complete run compared frame by frame against the model.
    task automatic run_seq(input bit m, input int mb, input int sb, input int rb, input bit poke);
        int gap_idx;
        master_sel = m; mu_bad = mb; sync_bad = sb; rx_bad = rb;
        n_mu = 0; n_sync = 0; n_rx = 0; ntr = 0;
        build(m, mb, sb, rb);
        pulse_start;
        chk(busy && !done && fail_code == 0, "R9 start clears", {busy, done, fail_code}, 4'b1000);
        if (poke) begin
            repeat (300) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        while (busy) @(negedge clk);
        chk(ntr == nexp, "R3 frame count", ntr, nexp);
        for (int i = 0; i < nexp && i < ntr; i++) begin
            if (exq[i][11:8] == 4'h0 && exq[i][15:8] == 8'h10)
                chk(lg[i] == exq[i], "R4 sync value", lg[i], exq[i]);
            else
                chk(lg[i] == exq[i], "R3 frame", lg[i], exq[i]);
        end
        chk(done == (exp_fail == 0), "R9 done", done, exp_fail == 0);
        chk(fail_code == exp_fail[1:0], exp_fail == 1 ? "R6 code" :
            exp_fail == 2 ? "R7 code" : exp_fail == 3 ? "R8 code" : "R9 code",
            fail_code, exp_fail);
        chk(tend[0] - tst[0] == 32 * CLK_DIV, "R2 frame length", tend[0] - tst[0], 32 * CLK_DIV);
        gap_idx = -1;
        for (int i = 1; i < ntr; i++) begin
            if (lg[i] == 16'hAA00 && gap_idx < 0) begin
                gap_idx = i;
                chk(tst[i] - tend[i-1] >= W_MU, "R5 mu wait", tst[i] - tend[i-1], W_MU);
            end
            if (lg[i] == 16'h8D00)
                chk(tst[i] - tend[i-1] >= W_SYNC, "R5 sync wait", tst[i] - tend[i-1], W_SYNC);
            if (lg[i] == 16'hA100)
                chk(tst[i] - tend[i-1] >= W_RX, "R5 rx wait", tst[i] - tend[i-1], W_RX);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(spi_cs_n && !spi_sclk && !busy && !done && fail_code == 0, "R1 in reset",
            {spi_cs_n, spi_sclk, busy, done, fail_code}, 6'b100000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n && !spi_sclk && !busy && !done && fail_code == 0, "R1 after reset",
            {spi_cs_n, spi_sclk, busy, done, fail_code}, 6'b100000);
    endtask

    task automatic t_hold(input int expf);
        int n0;
        n0 = ntr;
        repeat (200) @(negedge clk);
        chk(done == (expf == 0) && fail_code == expf[1:0] && ntr == n0 && !busy,
            "R9 hold", {done, fail_code}, {expf == 0, expf[1:0]});
    endtask

    task automatic t_success_master;  run_seq(1'b1, 0, 0, 0, 1'b0); t_hold(0); endtask
    task automatic t_success_slave;   run_seq(1'b0, 0, 0, 0, 1'b1); endtask  // R10
    task automatic t_mu_retry;        run_seq(1'b1, 2, 0, 0, 1'b0); endtask  // R6
    task automatic t_mu_fail;         run_seq(1'b1, 3, 0, 0, 1'b0); t_hold(1); endtask
    task automatic t_sync_retry;      run_seq(1'b0, 2, 1, 0, 1'b0); endtask  // R7 masked bits
    task automatic t_sync_fail;       run_seq(1'b1, 0, 5, 0, 1'b0); t_hold(2); endtask
    task automatic t_rx_retry;        run_seq(1'b1, 1, 1, 2, 1'b0); endtask  // R8
    task automatic t_rx_fail;         run_seq(1'b0, 0, 0, 3, 1'b0); t_hold(3); endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset;
        t_success_master;
        t_success_slave;
        t_mu_retry;
        t_mu_fail;
        t_sync_retry;
        t_sync_fail;
        t_rx_retry;
        t_rx_fail;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule